// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block puts a small word-organised shared memory behind a single arbitration point. Several requesters each present one operation at a time. A round-robin arbiter picks one of them. The unit then reads the addressed word, computes a replacement from the opcode and the request's operand and compare value, writes the replacement back, and returns the word as it stood before the operation. Reset clears the whole memory.

Once a request is accepted, the memory is held by that one operation. The read cycle and the write cycle belong to it, and no other request is accepted until the write has happened. A requester can therefore use the primitives to build locks, counters, flags and shared bit-maps without any other help.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, every memory word reads 0, all `rsp_valid` bits are 0, and no `req_ready` bit is high while no `req_valid` is high.
- R2: At most one `req_ready` bit is high at a time, and only for a requester whose `req_valid` is high. A request is accepted in a cycle where its valid and ready are both high. Exactly three cycles later, that requester's `rsp_valid` is high for one cycle, and `rsp_data` then carries the word's value from before the operation. No other `rsp_valid` bit is high in that cycle.
- R3: The grant rotates round-robin. After reset, requester 0 has the highest priority. After each acceptance, the requester following the one just served has the highest priority.
- R4: Opcode 0 (test-and-set) stores 1 when the word is 0 and leaves a nonzero word unchanged.
- R5: Opcode 1 (swap) stores the operand.
- R6: Opcode 2 (compare-and-swap) stores the operand only when the word equals the compare value. Otherwise the word is unchanged.
- R7: Opcode 3 (fetch-and-decrement) stores the word minus one, and leaves a word of 0 at 0.
- R8: Opcode 4 (fetch-and-add) stores the word plus the operand, modulo 2^16.
- R9: Opcode 5 stores the word AND the operand. Opcode 6 stores the word OR the operand.
- R10: Opcode 7 (fetch) returns the word and writes nothing.
- R11: Between an acceptance and its write, no other request is accepted. Concurrent operations on one word are serialised, so each one sees the results of all operations granted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_ready | output | N_REQ | Request accepted, one bit per requester |
| req_op | input | 3*N_REQ | Opcode, 3 bits per requester |
| req_addr | input | clog2(DEPTH)*N_REQ | Word address per requester |
| req_operand | input | DATA_W*N_REQ | Operand per requester |
| req_cmp | input | DATA_W*N_REQ | Compare value per requester |
| rsp_valid | output | N_REQ | One-cycle response pulse per requester |
| rsp_data | output | DATA_W | Old word, meaningful while a `rsp_valid` bit is high |

## Verification
Each primitive is tried on words chosen to hit both sides of its write condition:
- test-and-set on zero and on nonzero words;
- compare-and-swap with a matching and a mismatching compare value;
- decrement down through one to zero and then again at zero;
- addition across the 16-bit wrap.

A fetch after each operation tells a wrong stored value apart from a wrong returned value.

Two rounds with all four requesters adding distinct powers of two to one word give two results. The grant order separates round-robin from fixed priority. The returned prefix sums show whether operations were truly serialised or overlapped.

// File: rtl/atom_pkg.sv
// Shared types for the atomic read-modify-write unit.
// Assumes a 3-bit opcode space, all eight codes used.
package atom_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_TAS   = 3'd0,
        OP_SWAP  = 3'd1,
        OP_CAS   = 3'd2,
        OP_FDEC  = 3'd3,
        OP_FADD  = 3'd4,
        OP_FAND  = 3'd5,
        OP_FOR   = 3'd6,
        OP_FETCH = 3'd7
    } atom_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } atom_state_e;
endpackage

// File: rtl/atom_rr_arbiter.sv
// Round-robin arbiter: picks the first valid requester after the last one
// served. Assumes the pointer is advanced only when a grant is taken.
module atom_rr_arbiter #(
    parameter int N_REQ = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REQ-1:0]         req,
    input  logic                     take,
    output logic [N_REQ-1:0]         gnt,
    output logic [$clog2(N_REQ)-1:0] gnt_idx
);
    localparam int IDX_W = $clog2(N_REQ);

    logic [IDX_W-1:0] last_q;

    // Search from last_q+1 around the ring for the first valid request.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = N_REQ; k >= 1; k--) begin
            int cand;
            cand = (int'(last_q) + k) % N_REQ;
            if (req[cand]) begin
                gnt     = '0;
                gnt[cand] = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end

    // Remember the requester just served; reset makes requester 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N_REQ - 1);
        else if (take)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/atom_alu.sv
// Combinational datapath: from the old word and request fields, form the
// replacement word and whether it is written. Assumes unsigned wrap on add.
module atom_alu #(
    parameter int DATA_W = 16
) (
    input  atom_pkg::atom_op_e  op,
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   operand,
    input  logic [DATA_W-1:0]   cmp,
    output logic [DATA_W-1:0]   new_word,
    output logic                wr_en
);
    import atom_pkg::*;

    // Decode the opcode into result and write condition.
    always_comb begin
        new_word = old_word;
        wr_en    = 1'b0;
        unique case (op)
            OP_TAS:   begin new_word = DATA_W'(1);          wr_en = (old_word == '0); end
            OP_SWAP:  begin new_word = operand;             wr_en = 1'b1; end
            OP_CAS:   begin new_word = operand;             wr_en = (old_word == cmp); end
            OP_FDEC:  begin new_word = old_word - DATA_W'(1); wr_en = (old_word != '0); end
            OP_FADD:  begin new_word = old_word + operand;  wr_en = 1'b1; end
            OP_FAND:  begin new_word = old_word & operand;  wr_en = 1'b1; end
            OP_FOR:   begin new_word = old_word | operand;  wr_en = 1'b1; end
            OP_FETCH: begin new_word = old_word;            wr_en = 1'b0; end
            default:  begin new_word = old_word;            wr_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/atom_word_mem.sv
// Register-based word memory, one asynchronous read port and one write port.
// Assumes a small depth; reset clears all words.
module atom_word_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    // Clear on reset, otherwise store on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
// Atomic read-modify-write unit: arbitrates N_REQ requesters round-robin
// and runs one locked read cycle then write cycle per accepted request.
// Assumes requesters hold their fields stable while valid is high.
module atomic_rmw_unit #(
    parameter int N_REQ  = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_REQ-1:0]                 req_valid,
    output logic [N_REQ-1:0]                 req_ready,
    input  logic [N_REQ*3-1:0]               req_op,
    input  logic [N_REQ*$clog2(DEPTH)-1:0]   req_addr,
    input  logic [N_REQ*DATA_W-1:0]          req_operand,
    input  logic [N_REQ*DATA_W-1:0]          req_cmp,
    output logic [N_REQ-1:0]                 rsp_valid,
    output logic [DATA_W-1:0]                rsp_data
);
    import atom_pkg::*;

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int IDX_W  = $clog2(N_REQ);

    atom_state_e        state_q;
    logic [IDX_W-1:0]   owner_q;
    atom_op_e           op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  opnd_q, cmp_q, old_q, rsp_data_q;
    logic [N_REQ-1:0]   rsp_valid_q;

    logic [N_REQ-1:0]   gnt;
    logic [IDX_W-1:0]   gnt_idx;
    logic               accept;
    logic [DATA_W-1:0]  rd_data, new_word;
    logic               alu_we, mem_we, st_write;

    atom_rr_arbiter #(.N_REQ(N_REQ)) i_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid), .take(accept),
        .gnt(gnt), .gnt_idx(gnt_idx)
    );

    // Offer the grant only while idle; the lock holds otherwise.
    assign req_ready = (state_q == ST_IDLE) ? gnt : '0;
    assign accept    = |(req_valid & req_ready);
    assign st_write  = (state_q == ST_WRITE);
    assign mem_we    = st_write && alu_we;

    atom_alu #(.DATA_W(DATA_W)) i_alu (
        .op(op_q), .old_word(old_q), .operand(opnd_q), .cmp(cmp_q),
        .new_word(new_word), .wr_en(alu_we)
    );

    atom_word_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(rd_data),
        .we(mem_we), .wr_addr(addr_q), .wr_data(new_word)
    );

    // Sequence accept -> read -> write and latch the granted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            owner_q     <= '0;
            op_q        <= OP_FETCH;
            addr_q      <= '0;
            opnd_q      <= '0;
            cmp_q       <= '0;
            old_q       <= '0;
            rsp_valid_q <= '0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= '0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    owner_q <= gnt_idx;
                    op_q    <= atom_op_e'(req_op[gnt_idx*OP_W +: OP_W]);
                    addr_q  <= req_addr[gnt_idx*ADDR_W +: ADDR_W];
                    opnd_q  <= req_operand[gnt_idx*DATA_W +: DATA_W];
                    cmp_q   <= req_cmp[gnt_idx*DATA_W +: DATA_W];
                    state_q <= ST_READ;
                end
                ST_READ: begin
                    old_q   <= rd_data;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    rsp_valid_q          <= '0;
                    rsp_valid_q[owner_q] <= 1'b1;
                    rsp_data_q           <= old_q;
                    state_q              <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/atom_rmw_checker.sv
// Property checker for atomic_rmw_unit, attached by bind below.
// Assumes the top's internal write-phase, opcode and old-word registers.
module atom_rmw_checker #(
    parameter int N_REQ  = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_REQ-1:0]  req_valid,
    input logic [N_REQ-1:0]  req_ready,
    input logic [N_REQ-1:0]  rsp_valid,
    input logic              in_write,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] old,
    input logic              mem_we
);
    localparam int IDX_W = $clog2(N_REQ);

    logic [N_REQ-1:0] acc_vec;
    logic             acc;
    logic [IDX_W-1:0] acc_idx, last_q;
    logic             have_last_q, rr_bad;

    assign acc_vec = req_valid & req_ready;
    assign acc     = |acc_vec;

    // Index of the accepted requester and repeat-while-others-wait flag.
    always_comb begin
        acc_idx = '0;
        for (int i = 0; i < N_REQ; i++)
            if (acc_vec[i]) acc_idx = IDX_W'(i);
        rr_bad = acc && have_last_q && (acc_idx == last_q) &&
                 ((req_valid & ~(N_REQ'(1) << last_q)) != '0);
    end

    // Track the last served requester.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q      <= '0;
            have_last_q <= 1'b0;
        end else if (acc) begin
            last_q      <= acc_idx;
            have_last_q <= 1'b1;
        end
    end

    assert_one_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    assert_ready_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
    assert_rsp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##3 ($countones(rsp_valid) == 1));
    assert_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (req_ready == '0) ##1 (req_ready == '0));
    assert_rr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rr_bad);
    assert_tas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_write && op == 3'd0 && old != '0) |-> !mem_we);
    assert_fdec_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_write && op == 3'd3 && old == '0) |-> !mem_we);
    assert_fetch_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_write && op == 3'd7) |-> !mem_we);
endmodule

bind atomic_rmw_unit atom_rmw_checker #(.N_REQ(N_REQ), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .in_write(st_write), .op(op_q), .old(old_q),
    .mem_we(mem_we)
);

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
    localparam int N = 4;
    localparam int DW = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  req_valid = '0;
    logic [N-1:0]  req_ready;
    logic [N*3-1:0]  req_op = '0;
    logic [N*4-1:0]  req_addr = '0;
    logic [N*DW-1:0] req_operand = '0;
    logic [N*DW-1:0] req_cmp = '0;
    logic [N-1:0]  rsp_valid;
    logic [DW-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int last_acc = N - 1;
    logic [DW-1:0] got [N];

    always #5 clk = ~clk;

    atomic_rmw_unit i_atomic_rmw_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_operand(req_operand),
        .req_cmp(req_cmp), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Capture the response of each requester.
    always @(negedge clk)
        for (int i = 0; i < N; i++) if (rsp_valid[i]) got[i] = rsp_data;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_req(input int r, input logic [2:0] op, input logic [3:0] a,
                           input logic [15:0] opnd, input logic [15:0] cv);
        req_op[r*3 +: 3]       = op;
        req_addr[r*4 +: 4]     = a;
        req_operand[r*DW +: DW] = opnd;
        req_cmp[r*DW +: DW]    = cv;
        req_valid[r]           = 1'b1;
    endtask

    // One operation from requester r; checks response timing (R2).
    task automatic issue(input int r, input logic [2:0] op, input logic [3:0] a,
                         input logic [15:0] opnd, input logic [15:0] cv,
                         output logic [15:0] old);
        @(negedge clk);
        set_req(r, op, a, opnd, cv);
        #1;
        while (!req_ready[r]) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid[r] = 1'b0;
        last_acc = r;
        @(negedge clk);
        @(negedge clk);
        chk("R2 no early response", 32'(rsp_valid), 32'h0);
        @(negedge clk);
        chk("R2 response pulse", 32'(rsp_valid), 32'(1 << r));
        old = rsp_data;
        @(negedge clk);
        chk("R2 pulse ends", 32'(rsp_valid), 32'h0);
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        issue(1, 3'd7, a, 16'h0, 16'h0, v);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        @(negedge clk);
        chk("R1 rsp_valid idle", 32'(rsp_valid), 32'h0);
        chk("R1 no ready idle", 32'(req_ready), 32'h0);
        for (int a = 0; a < 16; a++) begin
            peek(4'(a), v);
            chk("R1 word cleared", 32'(v), 32'h0);
        end
    endtask

    task automatic t_tas;
        logic [15:0] v;
        issue(0, 3'd0, 4'd2, 16'h0, 16'h0, v); chk("R4 tas old zero", 32'(v), 32'h0);
        peek(4'd2, v);                          chk("R4 tas sets 1", 32'(v), 32'h1);
        issue(2, 3'd0, 4'd2, 16'h0, 16'h0, v); chk("R4 tas old one", 32'(v), 32'h1);
        issue(0, 3'd1, 4'd3, 16'h0005, 16'h0, v);
        issue(3, 3'd0, 4'd3, 16'h0, 16'h0, v); chk("R4 tas returns 5", 32'(v), 32'h5);
        peek(4'd3, v);                          chk("R4 tas keeps 5", 32'(v), 32'h5);
    endtask

    task automatic t_swap_cas;
        logic [15:0] v;
        issue(1, 3'd1, 4'd4, 16'hA5A5, 16'h0, v); chk("R5 swap old", 32'(v), 32'h0);
        peek(4'd4, v);                            chk("R5 swap stored", 32'(v), 32'hA5A5);
        issue(2, 3'd2, 4'd4, 16'h1234, 16'hA5A4, v); chk("R6 cas miss old", 32'(v), 32'hA5A5);
        peek(4'd4, v);                            chk("R6 cas miss keeps", 32'(v), 32'hA5A5);
        issue(2, 3'd2, 4'd4, 16'h1234, 16'hA5A5, v); chk("R6 cas hit old", 32'(v), 32'hA5A5);
        peek(4'd4, v);                            chk("R6 cas hit stores", 32'(v), 32'h1234);
    endtask

    task automatic t_fdec_fadd;
        logic [15:0] v;
        issue(0, 3'd1, 4'd6, 16'h0002, 16'h0, v);
        issue(0, 3'd3, 4'd6, 16'h0, 16'h0, v); chk("R7 dec from 2", 32'(v), 32'h2);
        issue(3, 3'd3, 4'd6, 16'h0, 16'h0, v); chk("R7 dec from 1", 32'(v), 32'h1);
        issue(3, 3'd3, 4'd6, 16'h0, 16'h0, v); chk("R7 dec at 0", 32'(v), 32'h0);
        peek(4'd6, v);                          chk("R7 saturates 0", 32'(v), 32'h0);
        issue(0, 3'd1, 4'd7, 16'hFFFF, 16'h0, v);
        issue(2, 3'd4, 4'd7, 16'h0002, 16'h0, v); chk("R8 add old", 32'(v), 32'hFFFF);
        peek(4'd7, v);                          chk("R8 add wraps", 32'(v), 32'h0001);
    endtask

    task automatic t_bits;
        logic [15:0] v;
        issue(0, 3'd1, 4'd8, 16'hF0F0, 16'h0, v);
        issue(1, 3'd5, 4'd8, 16'h3C3C, 16'h0, v); chk("R9 and old", 32'(v), 32'hF0F0);
        peek(4'd8, v);                          chk("R9 and result", 32'(v), 32'h3030);
        issue(2, 3'd6, 4'd8, 16'h0101, 16'h0, v); chk("R9 or old", 32'(v), 32'h3030);
        peek(4'd8, v);                          chk("R9 or result", 32'(v), 32'h3131);
        issue(3, 3'd7, 4'd8, 16'hFFFF, 16'hFFFF, v); chk("R10 fetch value", 32'(v), 32'h3131);
        peek(4'd8, v);                          chk("R10 fetch no write", 32'(v), 32'h3131);
    endtask

    // All requesters add distinct powers of two to one word at once.
    task automatic t_contend(input logic [3:0] a);
        logic [15:0] v, base, run;
        int order [N];
        peek(a, base);
        @(negedge clk);
        for (int i = 0; i < N; i++) set_req(i, 3'd4, a, 16'(1 << i), 16'h0);
        for (int k = 0; k < N; k++) begin
            int idx;
            #1;
            while (req_ready == '0) begin @(negedge clk); #1; end
            chk("R2 single ready", 32'($countones(req_ready)), 32'h1);
            idx = 0;
            for (int i = 0; i < N; i++) if (req_ready[i]) idx = i;
            chk("R3 grant order", 32'(idx), 32'((last_acc + 1) % N));
            order[k] = idx;
            @(posedge clk); #1;
            req_valid[idx] = 1'b0;
            last_acc = idx;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        run = base;
        for (int k = 0; k < N; k++) begin
            chk("R11 serialised old", 32'(got[order[k]]), 32'(run));
            run = run + 16'(1 << order[k]);
        end
        peek(a, v);
        chk("R11 final sum", 32'(v), 32'(base + 16'h000F));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tas();
        t_swap_cas();
        t_fdec_fadd();
        t_bits();
        t_contend(4'd9);
        issue(2, 3'd7, 4'd0, 16'h0, 16'h0, v);
        t_contend(4'd10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule